// File: doc/BRIEF.md
# Card Reset and Clock Request Gating

This block produces two active-low control lines for a removable PCIe-style card slot. The first is the card's fundamental reset. The block holds it low until five conditions are all true:

- the auxiliary supply is valid;
- the system is active;
- a card is present;
- every supply rail reports power-good;
- both host reset lines are deasserted.

After all five hold, a programmable number of clock cycles must also pass before reset is released. The second line is the request that turns on the reference clock generator. It is pulled low only when the card is powered and present and both the host clock-enable and the card's own clock request are low. When the auxiliary supply is absent, this line is not driven.

Every input is asynchronous to the block clock and passes through a multi-stage synchronizer. The block reasons only on the synchronized copies.

Reset release waits on a counter. The counter must see an unbroken run of qualified cycles, so any dropout restarts it from zero. Reset re-assertion has no delay: it follows the synchronized inputs directly. The delay is a parameter in clock cycles. For example, a nominal 10 ms window, inside the allowed 4 ms to 20 ms range, is set by choosing the count that matches the clock frequency.

Top module: `card_rst_clk_gate`

## Requirements
- R1: While `rst_n` is low, `card_rst_n_o` is 0, `clkreq_oe_o` is 0 and `clkreq_n_o` is 1.
- R2: `card_rst_n_o` is 1 only if the synchronized `aux_ok_i`, `sys_on_i`, `card_in_i`, `host_rst_a_n_i`, `host_rst_b_n_i` and every bit of `rail_good_i` are all 1.
- R3: Suppose those six conditions become true together and then stay true. If the inputs change just after a clock edge, `card_rst_n_o` rises exactly SYNC_STAGES + DELAY_CYCLES rising edges later.
- R4: If any of those conditions goes false while `card_rst_n_o` is 1, `card_rst_n_o` falls after exactly SYNC_STAGES rising edges, with no extra delay.
- R5: If a condition drops before the delay completes, the count restarts. Reset is then released only SYNC_STAGES + DELAY_CYCLES edges after the conditions are restored.
- R6: While the synchronized `aux_ok_i` is 0, `clkreq_oe_o` is 0, `card_rst_n_o` is 0 and `clkreq_n_o` is held at 1.
- R7: `clkreq_oe_o` equals the synchronized `aux_ok_i`. `clkreq_n_o` is 0 exactly when the synchronized `aux_ok_i`, `sys_on_i`, `card_in_i` and all `rail_good_i` bits are 1 and both `host_clken_n_i` and `card_clkreq_n_i` are 0. Otherwise it is 1.
- R8: `clkreq_n_o` follows its inputs after exactly SYNC_STAGES rising edges and does not wait on the release counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aux_ok_i | input | 1 | Auxiliary supply valid |
| sys_on_i | input | 1 | System active (1) or standby (0) |
| card_in_i | input | 1 | Card present |
| host_rst_a_n_i | input | 1 | First host reset, active low |
| host_rst_b_n_i | input | 1 | Second host reset, active low |
| host_clken_n_i | input | 1 | Host clock enable, active low |
| card_clkreq_n_i | input | 1 | Card clock request, active low |
| rail_good_i | input | NUM_RAILS | Per-rail power-good flags |
| card_rst_n_o | output | 1 | Card fundamental reset, active low |
| clkreq_n_o | output | 1 | Reference clock request, active low |
| clkreq_oe_o | output | 1 | Drive enable for `clkreq_n_o` (0 = high impedance) |

## Verification
Two things can happen in the same cycle: the release counter reaches its limit, and a qualifying condition drops. The bench provokes this with a one-cycle host-reset glitch timed to arrive in the last counted cycle. It then checks two points. Reset must stay low at the moment it would otherwise have released. Release must then come exactly one full delay after the glitch ends. Clock request changes run alongside a live count, and the bench checks that they appear after the synchronizer latency alone.

// File: rtl/crg_pkg.sv
// Shared types for the card reset / clock request gating block.
// Assumes: all control inputs are single-bit level signals.
package crg_pkg;

    // Control inputs, grouped so they can be synchronized as one vector.
    typedef struct packed {
        logic aux_ok;
        logic sys_on;
        logic card_in;
        logic host_rst_a_n;
        logic host_rst_b_n;
        logic host_clken_n;
        logic card_clkreq_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/crg_sync.sv
// Multi-stage synchronizer for a vector of asynchronous level inputs.
// Assumes: bits are independent levels (no bus coherency is needed);
// STAGES >= 1; reset value is all zeros.
module crg_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First capture stage samples the raw inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= d_i;
            end
        end else begin : g_next
            // Later stages shift the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/crg_release_timer.sv
// Release delay counter. Counts consecutive cycles with qual_i high and
// raises done_o once DELAY_CYCLES such cycles have passed. Any low cycle
// clears the count and done_o at once.
// Assumes: DELAY_CYCLES >= 1.
module crg_release_timer #(
    parameter int DELAY_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    output logic done_o
);

    localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count qualified cycles, restart on any dropout, latch completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !qual_i) begin
            cnt    <= '0;
            done_o <= 1'b0;
        end else if (!done_o) begin
            if (cnt == LAST) done_o <= 1'b1;
            else             cnt    <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/crg_clkreq_gate.sv
// Reference clock request gating. Combines the host and card requests
// (both active low) with power and presence qualifiers. The output is
// parked high and undriven while the auxiliary supply is absent.
// Assumes: inputs are already synchronized.
module crg_clkreq_gate
    import crg_pkg::*;
(
    input  ctl_t ctl_i,
    input  logic pg_all_i,
    output logic clkreq_n_o,
    output logic clkreq_oe_o
);

    logic powered;

    // Decide whether the clock request may be pulled low.
    always_comb begin
        powered     = ctl_i.aux_ok & ctl_i.sys_on & ctl_i.card_in & pg_all_i;
        clkreq_n_o  = ~(powered & ~ctl_i.host_clken_n & ~ctl_i.card_clkreq_n);
        clkreq_oe_o = ctl_i.aux_ok;
    end

endmodule

// File: rtl/card_rst_clk_gate.sv
// Top of the card reset and clock request gating block.
// Synchronizes all control inputs, qualifies the reset release with a
// counted delay, and gates the clock request.
// Assumes: inputs are asynchronous levels; DELAY_CYCLES is set to match
// the wanted release delay at the block clock frequency.
module card_rst_clk_gate
    import crg_pkg::*;
#(
    parameter int NUM_RAILS    = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int DELAY_CYCLES = 10000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 aux_ok_i,
    input  logic                 sys_on_i,
    input  logic                 card_in_i,
    input  logic                 host_rst_a_n_i,
    input  logic                 host_rst_b_n_i,
    input  logic                 host_clken_n_i,
    input  logic                 card_clkreq_n_i,
    input  logic [NUM_RAILS-1:0] rail_good_i,
    output logic                 card_rst_n_o,
    output logic                 clkreq_n_o,
    output logic                 clkreq_oe_o
);

    localparam int SYNC_W = CTL_W + NUM_RAILS;

    ctl_t                 ctl_raw;
    ctl_t                 ctl_q;
    logic [NUM_RAILS-1:0] pg_q;
    logic                 pg_all;
    logic                 rst_qual;
    logic                 delay_done;

    // Gather raw control inputs into one struct.
    always_comb begin
        ctl_raw.aux_ok        = aux_ok_i;
        ctl_raw.sys_on        = sys_on_i;
        ctl_raw.card_in       = card_in_i;
        ctl_raw.host_rst_a_n  = host_rst_a_n_i;
        ctl_raw.host_rst_b_n  = host_rst_b_n_i;
        ctl_raw.host_clken_n  = host_clken_n_i;
        ctl_raw.card_clkreq_n = card_clkreq_n_i;
    end

    crg_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ctl_raw, rail_good_i}),
        .q_o   ({ctl_q, pg_q})
    );

    // Reset release qualifiers on the synchronized inputs.
    always_comb begin
        pg_all   = &pg_q;
        rst_qual = ctl_q.aux_ok & ctl_q.sys_on & ctl_q.card_in &
                   ctl_q.host_rst_a_n & ctl_q.host_rst_b_n & pg_all;
    end

    crg_release_timer #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual_i (rst_qual),
        .done_o (delay_done)
    );

    // Reset is released only with live qualifiers and a completed delay.
    assign card_rst_n_o = rst_qual & delay_done;

    crg_clkreq_gate u_clkreq (
        .ctl_i       (ctl_q),
        .pg_all_i    (pg_all),
        .clkreq_n_o  (clkreq_n_o),
        .clkreq_oe_o (clkreq_oe_o)
    );

endmodule

// File: rtl/card_rst_clk_gate_chk.sv
// Property checker for card_rst_clk_gate, attached by bind. Observes the
// synchronized inputs and the outputs, and keeps its own run-length
// counter of qualified cycles to check the release delay.
module card_rst_clk_gate_chk
    import crg_pkg::*;
#(
    parameter int NUM_RAILS    = 3,
    parameter int DELAY_CYCLES = 10000
) (
    input logic                 clk,
    input logic                 rst_n,
    input ctl_t                 ctl_q,
    input logic [NUM_RAILS-1:0] pg_q,
    input logic                 card_rst_n_o,
    input logic                 clkreq_n_o,
    input logic                 clkreq_oe_o
);

    localparam int RUN_W = $clog2(DELAY_CYCLES + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(DELAY_CYCLES + 1);

    logic             ok_rst;
    logic             ok_clk;
    logic [RUN_W-1:0] run;

    // Independent view of the qualification terms.
    always_comb begin
        ok_rst = (pg_q == {NUM_RAILS{1'b1}}) && ctl_q.aux_ok && ctl_q.sys_on &&
                 ctl_q.card_in && ctl_q.host_rst_a_n && ctl_q.host_rst_b_n;
        ok_clk = (pg_q == {NUM_RAILS{1'b1}}) && ctl_q.aux_ok && ctl_q.sys_on &&
                 ctl_q.card_in && !ctl_q.host_clken_n && !ctl_q.card_clkreq_n;
    end

    // Length of the current unbroken qualified run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !ok_rst) run <= '0;
        else if (run != RUN_CAP) run <= run + 1'b1;
    end

    AST_RELEASE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_n_o |-> ok_rst); // R2
    AST_RELEASE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n_o) |-> (run == RUN_W'(DELAY_CYCLES))); // R3
    AST_DROP_ASSERTS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ok_rst) |-> !card_rst_n_o); // R4
    AST_AUX_ABSENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.aux_ok |-> (!clkreq_oe_o && !card_rst_n_o && clkreq_n_o)); // R6
    AST_CLKREQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !clkreq_n_o |-> (clkreq_oe_o && ok_clk)); // R7
    AST_CLKREQ_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        ok_clk |-> !clkreq_n_o); // R7

endmodule

bind card_rst_clk_gate card_rst_clk_gate_chk #(
    .NUM_RAILS    (NUM_RAILS),
    .DELAY_CYCLES (DELAY_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_q        (ctl_q),
    .pg_q         (pg_q),
    .card_rst_n_o (card_rst_n_o),
    .clkreq_n_o   (clkreq_n_o),
    .clkreq_oe_o  (clkreq_oe_o)
);

// File: tb/card_rst_clk_gate_bench.sv
module card_rst_clk_gate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RAILS      = 3;
    localparam int SYNC       = 2;
    localparam int DELAY      = 5;
    localparam int STIM_W     = 7 + RAILS;
    localparam logic [STIM_W-1:0] ALL_ON = {7'b1111111, {RAILS{1'b1}}};

    logic             clk = 1'b0;
    logic             rst_n;
    logic [STIM_W-1:0] stim;
    logic             card_rst_n_o, clkreq_n_o, clkreq_oe_o;

    int checks = 0;
    int fails  = 0;

    // stim = {aux, sys, card, rst_a_n, rst_b_n, clken_n, clkreq_n, rails}
    card_rst_clk_gate #(
        .NUM_RAILS    (RAILS),
        .SYNC_STAGES  (SYNC),
        .DELAY_CYCLES (DELAY)
    ) u_card_rst_clk_gate (
        .clk             (clk),
        .rst_n           (rst_n),
        .aux_ok_i        (stim[STIM_W-1]),
        .sys_on_i        (stim[STIM_W-2]),
        .card_in_i       (stim[STIM_W-3]),
        .host_rst_a_n_i  (stim[STIM_W-4]),
        .host_rst_b_n_i  (stim[STIM_W-5]),
        .host_clken_n_i  (stim[STIM_W-6]),
        .card_clkreq_n_i (stim[STIM_W-7]),
        .rail_good_i     (stim[RAILS-1:0]),
        .card_rst_n_o    (card_rst_n_o),
        .clkreq_n_o      (clkreq_n_o),
        .clkreq_oe_o     (clkreq_oe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_rst_ok(input logic [STIM_W-1:0] v);
        return v[STIM_W-1] & v[STIM_W-2] & v[STIM_W-3] & v[STIM_W-4] &
               v[STIM_W-5] & (&v[RAILS-1:0]);
    endfunction

    function automatic logic exp_clk_n(input logic [STIM_W-1:0] v);
        return ~(v[STIM_W-1] & v[STIM_W-2] & v[STIM_W-3] & ~v[STIM_W-6] &
                 ~v[STIM_W-7] & (&v[RAILS-1:0]));
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        stim  = ALL_ON;
        wait_neg(4);
        // R1: reset state, even with all inputs active
        check("R1 rst_n_o", card_rst_n_o, 1'b0);
        check("R1 oe", clkreq_oe_o, 1'b0);
        check("R1 clkreq_n", clkreq_n_o, 1'b1);
        stim  = '0;
        rst_n = 1'b1;
        wait_neg(SYNC + 1);

        // R2 R6 R7: exhaustive sweep, steady-state after full latency
        for (int v = 0; v < (1 << STIM_W); v++) begin
            logic [STIM_W-1:0] s;
            s    = STIM_W'(v);
            stim = s;
            wait_neg(SYNC + DELAY + 1);
            check(s[STIM_W-1] ? "R2 rst_n_o" : "R6 rst_n_o", card_rst_n_o, exp_rst_ok(s));
            check("R7 oe", clkreq_oe_o, s[STIM_W-1]);
            check(s[STIM_W-1] ? "R7 clkreq_n" : "R6 clkreq_n", clkreq_n_o, exp_clk_n(s));
        end

        // R3: exact release cycle from a cleared state
        stim = '0;
        wait_neg(SYNC + 2);
        stim = ALL_ON;
        wait_neg(SYNC + DELAY - 1);
        check("R3 early", card_rst_n_o, 1'b0);
        wait_neg(1);
        check("R3 release", card_rst_n_o, 1'b1);

        // R4: drop of system-active asserts reset after synchronizer only
        stim[STIM_W-2] = 1'b0;
        wait_neg(SYNC - 1);
        check("R4 before", card_rst_n_o, 1'b1);
        wait_neg(1);
        check("R4 asserted", card_rst_n_o, 1'b0);

        // R5: one-cycle host reset glitch in the last counted cycle
        stim = '0;
        wait_neg(SYNC + 2);
        stim = ALL_ON;
        wait_neg(DELAY - 1);
        stim[STIM_W-4] = 1'b0;
        wait_neg(1);
        stim[STIM_W-4] = 1'b1;
        wait_neg(SYNC - 1);
        check("R5 no early release", card_rst_n_o, 1'b0);
        wait_neg(DELAY);
        check("R5 still counting", card_rst_n_o, 1'b0);
        wait_neg(1);
        check("R5 release", card_rst_n_o, 1'b1);

        // R8: clock request latency independent of the release counter
        stim = '0;
        wait_neg(SYNC + 2);
        stim = ALL_ON;
        stim[STIM_W-6] = 1'b0;
        wait_neg(SYNC);
        check("R8 clk high", clkreq_n_o, 1'b1);
        stim[STIM_W-7] = 1'b0;
        wait_neg(SYNC - 1);
        check("R8 before", clkreq_n_o, 1'b1);
        wait_neg(1);
        check("R8 low mid-count", clkreq_n_o, 1'b0);
        check("R8 reset still held", card_rst_n_o, 1'b0);
        stim[STIM_W-6] = 1'b1;
        wait_neg(SYNC);
        check("R8 release", clkreq_n_o, 1'b1);

        // R6: aux loss stops driving and asserts reset
        stim = ALL_ON;
        wait_neg(SYNC + DELAY + 1);
        stim[STIM_W-1] = 1'b0;
        wait_neg(SYNC);
        check("R6 oe", clkreq_oe_o, 1'b0);
        check("R6 rst_n_o", card_rst_n_o, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule